// File: doc/BRIEF.md
# Relative Branch and Loop Resolver

This block settles, for one relative control transfer per cycle, whether the transfer is taken and which instruction pointer follows it. The caller presents the kind of transfer, a 4-bit condition code, the current arithmetic flags, the count register, the address of the next sequential instruction and a signed displacement. One clock later the block returns a taken bit, the next instruction pointer, and, for the count-down loop form, a decremented count together with a write strobe for the register file.

Four kinds are supported: an unconditional jump, a flag-conditional jump that covers the full set of signed and unsigned comparison predicates, a count-down loop that first decrements the count and then branches while the new count is nonzero, and a jump taken when the count is zero, tested on either the low 16 bits or the full count as selected per request. Decoding, far transfers, calls and returns are handled elsewhere.

Top module: `brResolver`

## Requirements
- R1: While reset is held and on the first edge after it, outValid, taken, cntWe, nextIp and cntOut are all zero.
- R2: For brKind=1 (flag-conditional), the flags port is {OF,SF,ZF,PF,CF} with CF at bit 0; code 2 is taken when CF=1, code 3 when CF=0, code 6 when CF or ZF is 1, and code 7 when both CF and ZF are 0.
- R3: For brKind=1, code 12 is taken when SF differs from OF, code 13 when they match, code 14 when ZF=1 or SF differs from OF, and code 15 when ZF=0 and SF matches OF.
- R4: For brKind=1, code 0 is taken on OF=1, code 4 on ZF=1, code 8 on SF=1, code 10 on PF=1, and each odd code 1, 5, 9, 11 is taken exactly when the code one below it is not.
- R5: For brKind=0 (unconditional) the transfer is always taken.
- R6: For brKind=3 (count-zero jump) the transfer is taken when the count is zero, testing all 32 bits when wideCnt=1 and only the low 16 bits when wideCnt=0.
- R7: For brKind=2 (loop) cntOut is the count minus one, wrapping from 0 to all-ones, cntWe is 1, and the transfer is taken exactly when that new count is nonzero.
- R8: A taken transfer targets seqIp plus the displacement; the loop form uses only the low 8 bits of disp, sign-extended (range -128 to 127), the other kinds use all 32 bits.
- R9: A transfer that is not taken gives nextIp equal to seqIp.
- R10: cntWe is 1 only for the loop form; for every other kind cntOut equals the count presented, unchanged.
- R11: Results appear exactly one cycle after a request with inValid=1; after a cycle with inValid=0, outValid, taken and cntWe are 0 and nextIp and cntOut hold their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request present this cycle |
| brKind | input | 2 | 0 unconditional, 1 flag-conditional, 2 loop, 3 count-zero |
| condCode | input | 4 | Condition selector for the flag-conditional kind |
| flags | input | 5 | {OF,SF,ZF,PF,CF} |
| wideCnt | input | 1 | Count width for the count-zero test: 1 full, 0 low 16 bits |
| counter | input | 32 | Current count register |
| seqIp | input | 32 | Address of the next sequential instruction |
| disp | input | 32 | Signed relative displacement |
| outValid | output | 1 | Result valid |
| taken | output | 1 | Transfer taken |
| nextIp | output | 32 | Next instruction pointer |
| cntOut | output | 32 | Count to write back |
| cntWe | output | 1 | Count write enable |

## Verification
Every condition code is driven against all 32 flag combinations, which separates each predicate from its neighbours and from its own negation, and sets the signed forms apart from the unsigned ones through cases where SF and OF disagree. Loop requests use counts of 0, 1, 2 and random values with displacements whose upper bits contradict the low byte, so the wrap, the stop on one and the 8-bit sign extension each show up at the ports. Count-zero requests with only the upper half set tell the 16-bit test from the 32-bit one, and idle cycles between requests show that the held outputs do not move.

// File: rtl/brPkg.sv
package brPkg;

  typedef enum logic [1:0] {
    KIND_ALWAYS  = 2'd0,
    KIND_FLAG    = 2'd1,
    KIND_LOOP    = 2'd2,
    KIND_CNTZERO = 2'd3
  } brKindE;

  // flag vector bit positions
  localparam int FLAG_CF = 0;
  localparam int FLAG_PF = 1;
  localparam int FLAG_ZF = 2;
  localparam int FLAG_SF = 3;
  localparam int FLAG_OF = 4;
  localparam int FLAG_W  = 5;

  // strobes from control to datapath
  typedef struct packed {
    logic take;
    logic writeCnt;
    logic shortDisp;
  } brStrobeT;

endpackage

// File: rtl/brControl.sv
module brControl
  import brPkg::*;
(
  input  logic [1:0]        brKind,
  input  logic [3:0]        condCode,
  input  logic [FLAG_W-1:0] flags,
  input  logic              wideCnt,
  input  logic              cntZeroWide,
  input  logic              cntZeroShort,
  input  logic              decNonZero,
  output brStrobeT          strobe
);

  logic cf, pf, zf, sf, ovf;
  logic signDiff;
  logic [7:0] basePred;
  logic condHit;

  assign cf  = flags[FLAG_CF];
  assign pf  = flags[FLAG_PF];
  assign zf  = flags[FLAG_ZF];
  assign sf  = flags[FLAG_SF];
  assign ovf = flags[FLAG_OF];
  assign signDiff = sf ^ ovf;

  // even-numbered predicates, indexed by condCode[3:1]
  always_comb begin
    basePred[0] = ovf;
    basePred[1] = cf;
    basePred[2] = zf;
    basePred[3] = cf | zf;
    basePred[4] = sf;
    basePred[5] = pf;
    basePred[6] = signDiff;
    basePred[7] = signDiff | zf;
  end

  assign condHit = basePred[condCode[3:1]] ^ condCode[0];

  always_comb begin
    strobe = '0;
    unique case (brKindE'(brKind))
      KIND_ALWAYS:  strobe.take = 1'b1;
      KIND_FLAG:    strobe.take = condHit;
      KIND_LOOP: begin
        strobe.take      = decNonZero;
        strobe.writeCnt  = 1'b1;
        strobe.shortDisp = 1'b1;
      end
      KIND_CNTZERO: strobe.take = wideCnt ? cntZeroWide : cntZeroShort;
      default:      strobe = '0;
    endcase
  end

endmodule

// File: rtl/brDatapath.sv
module brDatapath
  import brPkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int CNT_W       = 32,
  parameter int SHORT_W     = 16,
  parameter int LOOP_DISP_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  brStrobeT          strobe,
  input  logic [CNT_W-1:0]  counter,
  input  logic [ADDR_W-1:0] seqIp,
  input  logic [ADDR_W-1:0] disp,
  output logic              cntZeroWide,
  output logic              cntZeroShort,
  output logic              decNonZero,
  output logic              outValid,
  output logic              taken,
  output logic [ADDR_W-1:0] nextIp,
  output logic [CNT_W-1:0]  cntOut,
  output logic              cntWe
);

  localparam int EXT_W = ADDR_W - LOOP_DISP_W;

  logic [CNT_W-1:0]  cntDec;
  logic [ADDR_W-1:0] shortOff;
  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] target;

  assign cntDec      = counter - CNT_W'(1);
  assign decNonZero  = |cntDec;
  assign cntZeroWide = ~|counter;

  generate
    if (SHORT_W < CNT_W) begin : g_narrow
      assign cntZeroShort = ~|counter[SHORT_W-1:0];
    end else begin : g_same
      assign cntZeroShort = cntZeroWide;
    end
  endgenerate

  assign shortOff = {{EXT_W{disp[LOOP_DISP_W-1]}}, disp[LOOP_DISP_W-1:0]};
  assign offset   = strobe.shortDisp ? shortOff : disp;
  assign target   = seqIp + offset;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      taken    <= 1'b0;
      cntWe    <= 1'b0;
      nextIp   <= '0;
      cntOut   <= '0;
    end else begin
      outValid <= inValid;
      taken    <= inValid & strobe.take;
      cntWe    <= inValid & strobe.writeCnt;
      if (inValid) begin
        nextIp <= strobe.take ? target : seqIp;
        cntOut <= strobe.writeCnt ? cntDec : counter;
      end
    end
  end

endmodule

// File: rtl/brResolver.sv
module brResolver
  import brPkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int CNT_W       = 32,
  parameter int SHORT_W     = 16,
  parameter int LOOP_DISP_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [1:0]        brKind,
  input  logic [3:0]        condCode,
  input  logic [4:0]        flags,
  input  logic              wideCnt,
  input  logic [CNT_W-1:0]  counter,
  input  logic [ADDR_W-1:0] seqIp,
  input  logic [ADDR_W-1:0] disp,
  output logic              outValid,
  output logic              taken,
  output logic [ADDR_W-1:0] nextIp,
  output logic [CNT_W-1:0]  cntOut,
  output logic              cntWe
);

  brStrobeT strobe;
  logic cntZeroWide, cntZeroShort, decNonZero;

  brControl u_ctrl (
    .brKind       (brKind),
    .condCode     (condCode),
    .flags        (flags),
    .wideCnt      (wideCnt),
    .cntZeroWide  (cntZeroWide),
    .cntZeroShort (cntZeroShort),
    .decNonZero   (decNonZero),
    .strobe       (strobe)
  );

  brDatapath #(
    .ADDR_W      (ADDR_W),
    .CNT_W       (CNT_W),
    .SHORT_W     (SHORT_W),
    .LOOP_DISP_W (LOOP_DISP_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .inValid      (inValid),
    .strobe       (strobe),
    .counter      (counter),
    .seqIp        (seqIp),
    .disp         (disp),
    .cntZeroWide  (cntZeroWide),
    .cntZeroShort (cntZeroShort),
    .decNonZero   (decNonZero),
    .outValid     (outValid),
    .taken        (taken),
    .nextIp       (nextIp),
    .cntOut       (cntOut),
    .cntWe        (cntWe)
  );

endmodule

// File: rtl/brResolverChk.sv
module brResolverChk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [1:0]        brKind,
  input logic [CNT_W-1:0]  counter,
  input logic [ADDR_W-1:0] seqIp,
  input logic              outValid,
  input logic              taken,
  input logic [ADDR_W-1:0] nextIp,
  input logic [CNT_W-1:0]  cntOut,
  input logic              cntWe
);

  assert_latency_R11: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |-> outValid == $past(inValid));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> (!taken && !cntWe));

  assert_always_taken_R5: assert property (@(posedge clk) disable iff (!rstN)
    ($past(inValid) && $past(brKind) == 2'd0) |-> taken);

  assert_write_loop_only_R10: assert property (@(posedge clk) disable iff (!rstN)
    cntWe |-> ($past(inValid) && $past(brKind) == 2'd2));

  assert_decrement_R7: assert property (@(posedge clk) disable iff (!rstN)
    cntWe |-> (cntOut == $past(counter) - CNT_W'(1) && taken == (cntOut != '0)));

  assert_fallthrough_R9: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !taken) |-> nextIp == $past(seqIp));

endmodule

bind brResolver brResolverChk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .brKind   (brKind),
  .counter  (counter),
  .seqIp    (seqIp),
  .outValid (outValid),
  .taken    (taken),
  .nextIp   (nextIp),
  .cntOut   (cntOut),
  .cntWe    (cntWe)
);

// File: tb/brResolver_tb.sv
module brResolver_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [1:0]  brKind = 2'd0;
  logic [3:0]  condCode = 4'd0;
  logic [4:0]  flags = 5'd0;
  logic        wideCnt = 1'b0;
  logic [31:0] counter = 32'd0;
  logic [31:0] seqIp = 32'd0;
  logic [31:0] disp = 32'd0;
  logic        outValid, taken, cntWe;
  logic [31:0] nextIp, cntOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // expected state of the outputs after the next edge
  bit          eValid = 0, eTaken = 0, eWe = 0;
  logic [31:0] eIp = 0, eCnt = 0;
  string       eTag = "R1";

  always #4 clk = ~clk;

  brResolver u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .brKind(brKind),
    .condCode(condCode), .flags(flags), .wideCnt(wideCnt), .counter(counter),
    .seqIp(seqIp), .disp(disp), .outValid(outValid), .taken(taken),
    .nextIp(nextIp), .cntOut(cntOut), .cntWe(cntWe)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic bit condModel(input int cc, input logic [4:0] f);
    bit cf, pf, zf, sf, ovf;
    cf = f[0]; pf = f[1]; zf = f[2]; sf = f[3]; ovf = f[4];
    case (cc)
      0:  return ovf;
      1:  return !ovf;
      2:  return cf;
      3:  return !cf;
      4:  return zf;
      5:  return !zf;
      6:  return cf || zf;
      7:  return !cf && !zf;
      8:  return sf;
      9:  return !sf;
      10: return pf;
      11: return !pf;
      12: return sf != ovf;
      13: return sf == ovf;
      14: return zf || (sf != ovf);
      default: return !zf && (sf == ovf);
    endcase
  endfunction

  task automatic compareNow();
    chk("R11", "outValid", {31'd0, outValid}, {31'd0, eValid});
    chk(eValid ? eTag : "R11", "taken", {31'd0, taken}, {31'd0, eTaken});
    chk((eValid && !eTaken) ? "R9" : eTag, "nextIp", nextIp, eIp);
    chk(eWe ? eTag : "R10", "cntWe", {31'd0, cntWe}, {31'd0, eWe});
    chk(eWe ? eTag : "R10", "cntOut", cntOut, eCnt);
  endtask

  // one request per call; result is checked at the next call
  task automatic step(input bit v, input int kind, input int cc, input logic [4:0] f,
                      input bit wide, input logic [31:0] cnt, input logic [31:0] ip,
                      input logic [31:0] d, input string tag);
    logic [31:0] newCnt;
    bit tk;
    @(negedge clk);
    compareNow();
    inValid = v; brKind = kind[1:0]; condCode = cc[3:0]; flags = f;
    wideCnt = wide; counter = cnt; seqIp = ip; disp = d;
    eValid = v; eTaken = 0; eWe = 0; eTag = tag;
    if (v) begin
      newCnt = cnt;
      case (kind)
        0: tk = 1;
        1: tk = condModel(cc, f);
        2: begin newCnt = cnt - 1; tk = (newCnt != 0); eWe = 1; end
        default: tk = wide ? (cnt == 0) : (cnt[15:0] == 16'd0);
      endcase
      eTaken = tk;
      eCnt = newCnt;
      if (!tk) eIp = ip;
      else if (kind == 2) eIp = ip + {{24{d[7]}}, d[7:0]};
      else eIp = ip + d;
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    // R1: reset state observed while reset held
    @(negedge clk);
    chk("R1", "outValid in reset", {31'd0, outValid}, 32'd0);
    chk("R1", "nextIp in reset", nextIp, 32'd0);
    chk("R1", "cntOut in reset", cntOut, 32'd0);
    rstN = 1'b1;
    step(0, 0, 0, 0, 0, 0, 0, 0, "R1");

    // flag-conditional codes against every flag combination
    for (int f = 0; f < 32; f++) begin
      for (int c = 0; c < 16; c++) begin
        string t;
        if (c == 2 || c == 3 || c == 6 || c == 7) t = "R2";
        else if (c >= 12) t = "R3";
        else t = "R4";
        step(1, 1, c, f[4:0], 0, 32'h1234, 32'h0040_0000 + c * 16, 32'hFFFF_FF00 + f, t);
      end
    end

    // R5 unconditional, full 32-bit displacement (R8)
    step(1, 0, 5, 5'h04, 0, 32'h9, 32'h1000, 32'h0001_0000, "R5");
    step(1, 0, 0, 5'h00, 1, 32'h0, 32'h8000_0000, 32'hFFFF_FFF0, "R8");
    step(0, 2, 0, 0, 0, 32'h55, 32'h7777, 32'h9, "R11");
    step(0, 0, 0, 0, 0, 32'h66, 32'h8888, 32'h9, "R11");

    // R6 count-zero, width select
    step(1, 3, 0, 0, 1, 32'h0, 32'h2000, 32'h40, "R6");
    step(1, 3, 0, 0, 1, 32'h0001_0000, 32'h2000, 32'h40, "R6");
    step(1, 3, 0, 0, 0, 32'h0001_0000, 32'h2000, 32'h40, "R6");
    step(1, 3, 0, 0, 0, 32'h0000_0001, 32'h2000, 32'h40, "R6");
    step(1, 3, 0, 0, 0, 32'h0, 32'h2000, 32'hFFFF_0000, "R8");

    // R7 loop: wrap, stop on one, continue on two
    step(1, 2, 0, 0, 0, 32'h0, 32'h3000, 32'h10, "R7");
    step(1, 2, 0, 0, 0, 32'h1, 32'h3000, 32'h10, "R7");
    step(1, 2, 0, 0, 0, 32'h2, 32'h3000, 32'h10, "R7");
    // R8 loop displacement uses sign-extended low byte only
    step(1, 2, 0, 0, 1, 32'h5, 32'h3000, 32'h0000_0180, "R8");
    step(1, 2, 0, 0, 1, 32'h5, 32'h3000, 32'hFFFF_FF7F, "R8");
    step(1, 2, 0, 0, 1, 32'h5, 32'h0000_0010, 32'h1234_56F0, "R8");
    step(0, 1, 3, 0, 0, 32'h0, 32'h0, 32'h0, "R11");

    // mixed random traffic
    for (int i = 0; i < 600; i++) begin
      int k;
      logic [31:0] cnt;
      k = $urandom_range(0, 3);
      cnt = ($urandom_range(0, 3) == 0) ? {$urandom_range(0, 1) == 1 ? 16'h0 : 16'hA5A5, 16'h0}
                                         : $urandom;
      step($urandom_range(0, 4) != 0, k, $urandom_range(0, 15), 5'($urandom_range(0, 31)),
           $urandom_range(0, 1) == 1, cnt, $urandom, $urandom,
           k == 0 ? "R5" : k == 1 ? "R4" : k == 2 ? "R7" : "R6");
    end
    step(0, 0, 0, 0, 0, 0, 0, 0, "R11");
    step(0, 0, 0, 0, 0, 0, 0, 0, "R11");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule